// File: doc/BRIEF.md
# Three-Level DMA Address Walker

This block produces the byte-address stream for a single DMA channel. A transfer is described by a parameter set. Each set holds a source and a destination start address, three 16-bit counts, four signed 16-bit strides and a link pointer. The counts give bytes per element, elements per frame and frames per block. The block emits one beat per byte, carrying a source address, a destination address and three end markers. A downstream data mover takes beats through a valid/ready handshake and uses the markers to shape its bursts.

A small register array holds the parameter sets and is written one whole set at a time. The channel always runs from its own set, the set whose index is `CH`. A start pulse copies that set into working registers and begins the walk. When the block finishes, a one-cycle done pulse carries the completion code, which is the channel number. At the same moment, if the working link pointer is not all ones, the linked set is copied over the channel's own set. This arms the next transfer but does not start it. A start that arrives while a block is in progress is remembered and runs after the current block completes.

Top module: `dma3d_addr_gen`

## Requirements
- R1: After reset no beat is valid, done is low, and every parameter set has zero counts, zero addresses and strides, and an all-ones link.
- R2: A set is written whole through `pw_data`, with fields packed from bit 0 upward: source address (AW), destination address (AW), bytes per element, elements per frame, frames per block (CW each), source element stride, destination element stride, source frame stride, destination frame stride (IW each, two's complement), then the link (SW). A start runs set `CH`, and its first beat carries that set's source and destination addresses.
- R3: Within an element, successive beats step both addresses by one byte. An element has exactly as many beats as the bytes-per-element count.
- R4: The first byte of each later element in a frame sits at the previous element's first byte plus the signed element stride. The source and destination strides are independent.
- R5: The first byte of each new frame sits at the previous frame's first byte plus the signed frame stride, again separate for source and destination.
- R6: A block has exactly bytes×elements×frames beats, ordered bytes inside elements inside frames. `end_elem`, `end_frame` and `end_block` mark the last beat of the element, the frame and the block, and each implies the ones before it.
- R7: A beat advances only when `beat_valid` and `beat_ready` are both high. A stalled beat keeps its addresses and flags.
- R8: `done` is high for exactly one cycle, the cycle after the last beat is accepted, and `done_code` then equals `CH`.
- R9: At completion with a link other than all ones, set `CH` is replaced by the linked set. No beat follows until the next start, and that start runs the linked contents.
- R10: At completion with an all-ones link, set `CH` is left as it was, so a later start repeats the same block.
- R11: Any number of starts during a block (including its done cycle) collapse to one pending start. That start begins a new block right after the done cycle.
- R12: If any count is zero, a start produces `done` one cycle later with no beats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse for the channel |
| pw_en | input | 1 | Parameter set write enable |
| pw_sel | input | SW | Index of set being written |
| pw_data | input | SETW | Packed parameter set (layout in R2) |
| beat_valid | output | 1 | Beat address is valid |
| beat_ready | input | 1 | Downstream accepts the beat |
| src_addr | output | AW | Source byte address |
| dst_addr | output | AW | Destination byte address |
| end_elem | output | 1 | Last byte of an element |
| end_frame | output | 1 | Last byte of a frame |
| end_block | output | 1 | Last byte of the block |
| done | output | 1 | Block completion pulse |
| done_code | output | TCW | Completion code |

## Verification
The walk is tried with positive strides and an always-ready sink, which separates element stepping from frame stepping. It is then tried with negative and mixed-sign strides under an irregular ready pattern, which exposes sign-extension faults and beats lost or repeated during a stall. A single-byte block, a block with a zero count and the untouched reset set cover the degenerate shapes. Chained runs with and without a link, plus starts that land mid-block, show whether the reload arms without firing and whether pending starts collapse.

// File: rtl/dma3d_addr_gen.sv
module dma3d_addr_gen #(
  parameter int AW = 32,
  parameter int CW = 16,
  parameter int IW = 16,
  parameter int NSETS = 8,
  parameter int CH = 2,
  parameter int TCW = 6,
  localparam int SW = $clog2(NSETS),
  localparam int SETW = 2*AW + 3*CW + 4*IW + SW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            pw_en,
  input  logic [SW-1:0]   pw_sel,
  input  logic [SETW-1:0] pw_data,
  output logic            beat_valid,
  input  logic            beat_ready,
  output logic [AW-1:0]   src_addr,
  output logic [AW-1:0]   dst_addr,
  output logic            end_elem,
  output logic            end_frame,
  output logic            end_block,
  output logic            done,
  output logic [TCW-1:0]  done_code
);

  localparam int O_DST = AW;
  localparam int O_AC  = 2*AW;
  localparam int O_BC  = O_AC + CW;
  localparam int O_CC  = O_BC + CW;
  localparam int O_SB  = O_CC + CW;
  localparam int O_DB  = O_SB + IW;
  localparam int O_SC  = O_DB + IW;
  localparam int O_DC  = O_SC + IW;
  localparam int O_LK  = O_DC + IW;
  localparam logic [SW-1:0]   NO_LINK = '1;
  localparam logic [SETW-1:0] RST_SET = {NO_LINK, {(SETW-SW){1'b0}}};

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_FIN} state_t;

  function automatic logic [AW-1:0] sx(input logic [IW-1:0] v);
    return {{(AW-IW){v[IW-1]}}, v};
  endfunction

  logic [SETW-1:0] mem [NSETS];
  logic [SETW-1:0] cur;
  state_t          state;
  logic            pend;
  logic [CW-1:0]   w_ac, w_bc, w_cc, a_i, b_i, c_i;
  logic [IW-1:0]   w_sb, w_db, w_sc, w_dc;
  logic [SW-1:0]   w_lk;
  logic [AW-1:0]   s_elem, d_elem, s_frame, d_frame;
  logic            go, fire, zero_cnt;

  assign cur      = mem[CH];
  assign go       = start | pend;
  assign fire     = beat_valid & beat_ready;
  assign zero_cnt = (cur[O_AC +: CW] == '0) | (cur[O_BC +: CW] == '0) | (cur[O_CC +: CW] == '0);

  assign beat_valid = (state == S_RUN);
  assign src_addr   = s_elem + {{(AW-CW){1'b0}}, a_i};
  assign dst_addr   = d_elem + {{(AW-CW){1'b0}}, a_i};
  assign end_elem   = beat_valid & (a_i == w_ac - CW'(1));
  assign end_frame  = end_elem & (b_i == w_bc - CW'(1));
  assign end_block  = end_frame & (c_i == w_cc - CW'(1));
  assign done       = (state == S_FIN);
  assign done_code  = TCW'(CH);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NSETS; i++) mem[i] <= RST_SET;
    end else begin
      if (state == S_FIN && w_lk != NO_LINK) mem[CH] <= mem[w_lk];
      if (pw_en) mem[pw_sel] <= pw_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      pend    <= 1'b0;
      {w_ac, w_bc, w_cc, a_i, b_i, c_i} <= '0;
      {w_sb, w_db, w_sc, w_dc} <= '0;
      w_lk    <= NO_LINK;
      s_elem  <= '0;
      d_elem  <= '0;
      s_frame <= '0;
      d_frame <= '0;
    end else begin
      case (state)
        S_IDLE: if (go) begin
          pend    <= 1'b0;
          w_ac    <= cur[O_AC +: CW];
          w_bc    <= cur[O_BC +: CW];
          w_cc    <= cur[O_CC +: CW];
          w_sb    <= cur[O_SB +: IW];
          w_db    <= cur[O_DB +: IW];
          w_sc    <= cur[O_SC +: IW];
          w_dc    <= cur[O_DC +: IW];
          w_lk    <= cur[O_LK +: SW];
          s_elem  <= cur[0 +: AW];
          s_frame <= cur[0 +: AW];
          d_elem  <= cur[O_DST +: AW];
          d_frame <= cur[O_DST +: AW];
          a_i     <= '0;
          b_i     <= '0;
          c_i     <= '0;
          state   <= zero_cnt ? S_FIN : S_RUN;
        end
        S_RUN: begin
          if (start) pend <= 1'b1;
          if (fire) begin
            if (!end_elem) begin
              a_i <= a_i + CW'(1);
            end else begin
              a_i <= '0;
              if (!end_frame) begin
                b_i    <= b_i + CW'(1);
                s_elem <= s_elem + sx(w_sb);
                d_elem <= d_elem + sx(w_db);
              end else begin
                b_i <= '0;
                if (!end_block) begin
                  c_i     <= c_i + CW'(1);
                  s_frame <= s_frame + sx(w_sc);
                  d_frame <= d_frame + sx(w_dc);
                  s_elem  <= s_frame + sx(w_sc);
                  d_elem  <= d_frame + sx(w_dc);
                end else begin
                  state <= S_FIN;
                end
              end
            end
          end
        end
        default: begin
          if (start) pend <= 1'b1;
          state <= S_IDLE;
        end
      endcase
    end
  end

  assert_stall_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && !beat_ready |=> beat_valid && $stable(src_addr) && $stable(dst_addr)
      && $stable(end_block));

  assert_flag_nest_R6: assert property (@(posedge clk) disable iff (!rst_n)
    end_block |-> end_frame && end_elem && beat_valid);

  assert_done_after_last_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fire && end_block |=> done);

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_no_beat_at_done_R12: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !beat_valid);

  assert_pending_kept_R11: assert property (@(posedge clk) disable iff (!rst_n)
    start && state != S_IDLE |=> pend || state == S_RUN);

endmodule

// File: tb/dma3d_addr_gen_test.sv
module dma3d_addr_gen_test;
  localparam int AW = 32, CW = 16, IW = 16, NSETS = 8, CH = 2, TCW = 6;
  localparam int SW = $clog2(NSETS);
  localparam int SETW = 2*AW + 3*CW + 4*IW + SW;
  localparam logic [SW-1:0] NOL = '1;

  logic clk = 0;
  always #10 clk = ~clk;

  logic rst_n, start, pw_en, beat_ready;
  logic [SW-1:0] pw_sel;
  logic [SETW-1:0] pw_data;
  logic beat_valid, end_elem, end_frame, end_block, done;
  logic [AW-1:0] src_addr, dst_addr;
  logic [TCW-1:0] done_code;

  dma3d_addr_gen #(.AW(AW), .CW(CW), .IW(IW), .NSETS(NSETS), .CH(CH), .TCW(TCW)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .pw_en(pw_en), .pw_sel(pw_sel),
    .pw_data(pw_data), .beat_valid(beat_valid), .beat_ready(beat_ready),
    .src_addr(src_addr), .dst_addr(dst_addr), .end_elem(end_elem),
    .end_frame(end_frame), .end_block(end_block), .done(done), .done_code(done_code));

  int checks = 0, fails = 0, dones = 0, exp_dones = 0;
  string tag = "R1";
  logic [2*AW+2:0] q[$];
  bit rmode = 0;
  logic [7:0] lfsr = 8'h5a;

  task automatic chk(input bit ok, input string what, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #1;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    beat_ready = rmode ? lfsr[0] : 1'b1;
  end

  logic prev_stall = 0, prev_last = 0, prev_done = 0;
  logic [2*AW+2:0] prev_beat;
  always @(negedge clk) begin
    logic [2*AW+2:0] got, exp;
    if (rst_n) begin
      got = {src_addr, dst_addr, end_elem, end_frame, end_block};
      if (prev_stall) chk(beat_valid && got == prev_beat, "R7 stalled beat changed", got, prev_beat);
      if (prev_last) chk(done == 1'b1, "R8 done after last beat", done, 1);
      if (prev_done) chk(done == 1'b0, "R8 done longer than one cycle", done, 0);
      if (done) begin
        dones++;
        chk(done_code == TCW'(CH), "R8 completion code", done_code, CH);
      end
      if (beat_valid && beat_ready) begin
        if (q.size() == 0) chk(0, "R6/R12 unexpected beat", got, 0);
        else begin
          exp = q.pop_front();
          chk(got == exp, "R3/R4/R5/R6 beat", got, exp);
        end
      end
      prev_stall = beat_valid && !beat_ready;
      prev_last  = beat_valid && beat_ready && end_block;
      prev_done  = done;
      prev_beat  = got;
    end
  end

  function automatic logic [SETW-1:0] mkset(input logic [AW-1:0] s, d, input logic [CW-1:0] a, b, c,
      input logic [IW-1:0] sb, db, sc, dc, input logic [SW-1:0] lk);
    return {lk, dc, sc, db, sb, c, b, a, d, s};
  endfunction

  task automatic push_block(input logic [SETW-1:0] p);
    logic [AW-1:0] s0, d0, sf, df;
    logic [CW-1:0] a, b, c;
    logic [IW-1:0] sb, db, sc, dc;
    {dc, sc, db, sb, c, b, a, d0, s0} = p[SETW-SW-1:0];
    for (int k = 0; k < int'(c); k++) begin
      sf = s0 + AW'(k) * {{(AW-IW){sc[IW-1]}}, sc};
      df = d0 + AW'(k) * {{(AW-IW){dc[IW-1]}}, dc};
      for (int j = 0; j < int'(b); j++)
        for (int i = 0; i < int'(a); i++)
          q.push_back({sf + AW'(j) * {{(AW-IW){sb[IW-1]}}, sb} + AW'(i),
                       df + AW'(j) * {{(AW-IW){db[IW-1]}}, db} + AW'(i),
                       i == int'(a) - 1, i == int'(a) - 1 && j == int'(b) - 1,
                       i == int'(a) - 1 && j == int'(b) - 1 && k == int'(c) - 1});
    end
    exp_dones++;
  endtask

  task automatic write_set(input int idx, input logic [SETW-1:0] p);
    @(posedge clk); #2;
    pw_en = 1; pw_sel = SW'(idx); pw_data = p;
    @(posedge clk); #2;
    pw_en = 0;
  endtask

  task automatic pulse_start();
    @(posedge clk); #2; start = 1;
    @(posedge clk); #2; start = 0;
  endtask

  task automatic wait_done();
    int n = 0;
    while (dones < exp_dones && n < 20000) begin @(posedge clk); n++; end
    @(posedge clk);
    chk(dones == exp_dones, "R8 done count", dones, exp_dones);
    chk(q.size() == 0, "R6 beats missing", q.size(), 0);
  endtask

  task automatic quiet(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(!beat_valid, "R9/R10 beat without start", beat_valid, 0);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [SETW-1:0] pa, pb;
    rst_n = 0; start = 0; pw_en = 0; pw_sel = '0; pw_data = '0; beat_ready = 1;
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    @(negedge clk);
    tag = "R1";
    chk(!beat_valid, "reset valid", beat_valid, 0);
    chk(!done, "reset done", done, 0);
    exp_dones++;
    pulse_start();
    wait_done();
    quiet(4);

    tag = "R2/R3/R4/R5/R10";
    pa = mkset(32'h1000, 32'h2000, 2, 3, 2, 16'd4, 16'd8, 16'd32, -16'sd16, NOL);
    write_set(CH, pa);
    push_block(pa); pulse_start(); wait_done();
    quiet(3);
    push_block(pa); pulse_start(); wait_done();

    tag = "R7";
    rmode = 1;
    pa = mkset(32'h8000_0010, 32'h40, 3, 4, 3, -16'sd7, 16'd5, -16'sd100, 16'd64, NOL);
    write_set(CH, pa);
    push_block(pa); pulse_start(); wait_done();

    tag = "R6";
    pa = mkset(32'h77, 32'h99, 1, 1, 1, 0, 0, 0, 0, NOL);
    write_set(CH, pa);
    push_block(pa); pulse_start(); wait_done();

    tag = "R12";
    pa = mkset(32'h10, 32'h20, 4, 0, 3, 1, 1, 1, 1, NOL);
    write_set(CH, pa);
    exp_dones++; pulse_start(); wait_done();
    quiet(3);

    tag = "R9";
    rmode = 0;
    pa = mkset(32'h100, 32'h300, 2, 2, 2, 16'd3, 16'd6, 16'd10, 16'd20, SW'(5));
    pb = mkset(32'h5000, 32'h6000, 1, 3, 2, -16'sd2, 16'd2, 16'd100, -16'sd100, NOL);
    write_set(5, pb);
    write_set(CH, pa);
    push_block(pa); pulse_start(); wait_done();
    quiet(5);
    push_block(pb); pulse_start(); wait_done();
    tag = "R10";
    push_block(pb); pulse_start(); wait_done();

    tag = "R11";
    rmode = 1;
    push_block(pb); push_block(pb);
    pulse_start();
    repeat (3) @(posedge clk);
    pulse_start();
    pulse_start();
    wait_done();
    quiet(4);

    summary();
  end
endmodule